// File: doc/BRIEF.md
# Modem Handshake Register Block

This block is the modem-handshake part of a 16550-style UART. A five-bit control register drives four active-low handshake outputs. Those outputs are data-terminal-ready, request-to-send and two general-purpose outputs. Bit 4 of the control register selects loopback. A status register reports the present level of the four active-low handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It also holds a sticky change flag for each input.

The external inputs pass through a synchronizer before their changes are detected. Reading the status register clears the change flags. A single interrupt request is raised while a change flag is set and the interrupt enable is on.

In loopback the control bits feed the status levels. The handshake output pins and the serial transmit pin are parked high. The serial transmit stream from the core is routed back into the serial receive stream.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control readback is 0x00, `dtr_n`, `rts_n`, `op1_n` and `op2_n` are all 1, `sts_rdata` is 0x00 while the inputs are idle high, and `msi_irq` is 0.
- R2: A control write stores `ctl_wdata[4:0]` on the clock edge. Bit 0 drives `dtr_n`, bit 1 drives `rts_n`, bit 2 drives `op1_n` and bit 3 drives `op2_n`, each inverted. `ctl_rdata` returns the stored bits with bits 7:5 reading 0.
- R3: Status bits 4, 5, 6 and 7 report the inverted levels of `cts_n`, `dsr_n`, `ri_n` and `cd_n` in that order. With the default two-stage synchronizer, a level is visible after the second clock edge following the input change.
- R4: Status bits 0, 1 and 3 are set by any change, in either direction, of `cts_n`, `dsr_n` and `cd_n` respectively. With the default synchronizer this happens on the third edge after the change. One input change sets its flag exactly once.
- R5: Status bit 2 is set only when `ri_n` goes from 0 to 1. A change of `ri_n` from 1 to 0 leaves it clear.
- R6: A clock edge with `sts_rd` high clears status bits 3:0. Bits 7:4 are not affected.
- R7: A change flag whose event is detected in the same cycle as a status read stays set after that read.
- R8: With control bit 4 set, the status levels come from the control register: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2 and carrier from bit 3. The external handshake inputs have no effect on the status register.
- R9: With control bit 4 set, all four handshake outputs and `tx_pin` are 1, `rx_core` follows `tx_core`, and `rx_pin` is ignored. With bit 4 clear, `tx_pin` follows `tx_core` and `rx_core` follows `rx_pin`.
- R10: `msi_irq` is 1 exactly when `msi_en` is 1 and any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_rd | input | 1 | Status read strobe, clears change flags |
| sts_rdata | output | 8 | Status register value |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_irq | output | 1 | Modem-status interrupt request |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| op1_n | output | 1 | General output 1, active low |
| op2_n | output | 1 | General output 2, active low |
| tx_core | input | 1 | Serial stream from the transmitter |
| tx_pin | output | 1 | Serial line output |
| rx_pin | input | 1 | Serial line input |
| rx_core | output | 1 | Serial stream to the receiver |

## Verification
The hardest case to reach is a change flag set in the very cycle that a status read clears the flags. External inputs reach the detector only after the synchronizer, so it is awkward to line that up through the pins. The bench uses loopback instead. A control write changes the looped level on one known edge, and the status read strobe is placed on the next edge. The flag must then survive. Loopback patterns that each raise a single control bit separate the four routing paths, so a swapped path shows up as a wrong status value.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

   localparam int MDM_LINES = 4;
   localparam int REG_W     = 8;
   localparam int CTL_BITS  = 5;

   // status line order: bit0 cts, bit1 dsr, bit2 ri, bit3 cd
   typedef struct packed {
      logic cd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_lines_t;

   typedef struct packed {
      logic loop;
      logic op2;
      logic op1;
      logic rts;
      logic dtr;
   } mdm_ctl_t;

   // ring input flags only its trailing edge (active level falling)
   localparam logic [MDM_LINES-1:0] TRAIL_ONLY_DEF = 4'b0100;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int                STAGES  = 2,
   parameter int                WIDTH   = 4,
   parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], din};
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int               WIDTH      = 4,
   parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   input  logic             clr,
   output logic [WIDTH-1:0] flag
);

   logic [WIDTH-1:0] prev;
   logic [WIDTH-1:0] hit;

   for (genvar g = 0; g < WIDTH; g++) begin : g_line
      if (TRAIL_MASK[g]) begin : g_trail
         assign hit[g] = prev[g] & ~cur[g];
      end else begin : g_any
         assign hit[g] = prev[g] ^ cur[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         flag <= '0;
      end else begin
         prev <= cur;
         flag <= (flag & ~{WIDTH{clr}}) | hit;
      end
   end

endmodule

// File: rtl/mdm_route.sv
module mdm_route
   import uart_mdm_pkg::*;
(
   input  mdm_ctl_t   ctl,
   input  mdm_lines_t ext_lvl,
   input  logic       tx_core,
   input  logic       rx_pin,
   output mdm_lines_t lvl,
   output logic       dtr_n,
   output logic       rts_n,
   output logic       op1_n,
   output logic       op2_n,
   output logic       tx_pin,
   output logic       rx_core
);

   always_comb begin
      if (ctl.loop) begin
         lvl.cts = ctl.rts;
         lvl.dsr = ctl.dtr;
         lvl.ri  = ctl.op1;
         lvl.cd  = ctl.op2;
      end else begin
         lvl = ext_lvl;
      end
   end

   assign dtr_n   = ctl.loop | ~ctl.dtr;
   assign rts_n   = ctl.loop | ~ctl.rts;
   assign op1_n   = ctl.loop | ~ctl.op1;
   assign op2_n   = ctl.loop | ~ctl.op2;
   assign tx_pin  = ctl.loop | tx_core;
   assign rx_core = ctl.loop ? tx_core : rx_pin;

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
   import uart_mdm_pkg::*;
#(
   parameter int                    SYNC_STAGES = 2,
   parameter logic [MDM_LINES-1:0]  TRAIL_MASK  = TRAIL_ONLY_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] ctl_wdata,
   output logic [REG_W-1:0] ctl_rdata,
   input  logic             sts_rd,
   output logic [REG_W-1:0] sts_rdata,
   input  logic             msi_en,
   output logic             msi_irq,
   input  logic             cts_n,
   input  logic             dsr_n,
   input  logic             ri_n,
   input  logic             cd_n,
   output logic             dtr_n,
   output logic             rts_n,
   output logic             op1_n,
   output logic             op2_n,
   input  logic             tx_core,
   output logic             tx_pin,
   input  logic             rx_pin,
   output logic             rx_core
);

   localparam int PAD_W = REG_W - CTL_BITS;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_modem_ctl: SYNC_STAGES must be at least 2");
   end
   if (REG_W != 2 * MDM_LINES) begin : g_bad_width
      $error("uart_modem_ctl: status register must hold level and change per line");
   end

   mdm_ctl_t         ctl_q;
   logic [MDM_LINES-1:0] raw_n;
   logic [MDM_LINES-1:0] sync_n;
   mdm_lines_t       ext_lvl;
   mdm_lines_t       lvl;
   logic [MDM_LINES-1:0] flag;
   logic             unused_wr_hi;

   assign unused_wr_hi = ^ctl_wdata[REG_W-1:CTL_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q <= mdm_ctl_t'(ctl_wdata[CTL_BITS-1:0]);
      end
   end

   assign raw_n = {cd_n, ri_n, dsr_n, cts_n};

   mdm_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (MDM_LINES),
      .RST_VAL ({MDM_LINES{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_n),
      .dout  (sync_n)
   );

   assign ext_lvl = mdm_lines_t'(~sync_n);

   mdm_route u_route (
      .ctl     (ctl_q),
      .ext_lvl (ext_lvl),
      .tx_core (tx_core),
      .rx_pin  (rx_pin),
      .lvl     (lvl),
      .dtr_n   (dtr_n),
      .rts_n   (rts_n),
      .op1_n   (op1_n),
      .op2_n   (op2_n),
      .tx_pin  (tx_pin),
      .rx_core (rx_core)
   );

   mdm_delta #(
      .WIDTH      (MDM_LINES),
      .TRAIL_MASK (TRAIL_MASK)
   ) u_delta (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (lvl),
      .clr   (sts_rd),
      .flag  (flag)
   );

   assign sts_rdata = {lvl, flag};
   assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};
   assign msi_irq   = msi_en & (|flag);

endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic [7:0] ctl_wdata,
   input logic [7:0] ctl_rdata,
   input logic [7:0] sts_rdata,
   input logic       msi_en,
   input logic       msi_irq,
   input logic       dtr_n,
   input logic       rts_n,
   input logic       op1_n,
   input logic       op2_n,
   input logic       tx_core,
   input logic       tx_pin,
   input logic       rx_core
);

   // R2
   ctl_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[4]) |=>
         (dtr_n == !$past(ctl_wdata[0])) && (rts_n == !$past(ctl_wdata[1])) &&
         (op1_n == !$past(ctl_wdata[2])) && (op2_n == !$past(ctl_wdata[3])));

   // R9
   loop_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[4] |-> (dtr_n && rts_n && op1_n && op2_n && tx_pin));

   // R9
   loop_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[4] |-> (rx_core == tx_core));

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en |-> !msi_irq);

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msi_irq |-> (sts_rdata[3:0] != 4'h0));

   // R10
   irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_en && (sts_rdata[3:0] != 4'h0)) |-> msi_irq);

endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (ctl_wr),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .sts_rdata (sts_rdata),
   .msi_en    (msi_en),
   .msi_irq   (msi_irq),
   .dtr_n     (dtr_n),
   .rts_n     (rts_n),
   .op1_n     (op1_n),
   .op2_n     (op2_n),
   .tx_core   (tx_core),
   .tx_pin    (tx_pin),
   .rx_core   (rx_core)
);

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       sts_rd = 1'b0;
   logic [7:0] sts_rdata;
   logic       msi_en = 1'b0;
   logic       msi_irq;
   logic       cts_n = 1'b1;
   logic       dsr_n = 1'b1;
   logic       ri_n = 1'b1;
   logic       cd_n = 1'b1;
   logic       dtr_n, rts_n, op1_n, op2_n;
   logic       tx_core = 1'b1;
   logic       tx_pin;
   logic       rx_pin = 1'b1;
   logic       rx_core;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uart_modem_ctl dut (
      .clk (clk), .rst_n (rst_n),
      .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .ctl_rdata (ctl_rdata),
      .sts_rd (sts_rd), .sts_rdata (sts_rdata),
      .msi_en (msi_en), .msi_irq (msi_irq),
      .cts_n (cts_n), .dsr_n (dsr_n), .ri_n (ri_n), .cd_n (cd_n),
      .dtr_n (dtr_n), .rts_n (rts_n), .op1_n (op1_n), .op2_n (op2_n),
      .tx_core (tx_core), .tx_pin (tx_pin), .rx_pin (rx_pin), .rx_core (rx_core)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic rd_sts(output logic [7:0] v);
      @(negedge clk);
      sts_rd = 1'b1;
      v = sts_rdata;
      @(negedge clk);
      sts_rd = 1'b0;
   endtask

   function automatic logic [3:0] pins();
      return {op2_n, op1_n, rts_n, dtr_n};
   endfunction

   task automatic t_reset();
      chk("R1 ctl readback", ctl_rdata, 8'h00);
      chk("R1 output pins", pins(), 4'hF);
      chk("R1 status", sts_rdata, 8'h00);
      chk("R1 irq", msi_irq, 1'b0);
   endtask

   task automatic t_ctrl();
      wr_ctl(8'h05);
      chk("R2 pins 0x05", pins(), 4'b1010);
      chk("R2 readback 0x05", ctl_rdata, 8'h05);
      wr_ctl(8'hEA);
      chk("R2 pins 0xEA", pins(), 4'b0101);
      chk("R2 readback upper zero", ctl_rdata, 8'h0A);
      wr_ctl(8'h00);
      chk("R2 pins cleared", pins(), 4'hF);
      @(negedge clk);
      tx_core = 1'b0;
      rx_pin = 1'b0;
      #1;
      chk("R9 tx follows core", tx_pin, 1'b0);
      chk("R9 rx follows pin", rx_core, 1'b0);
      tx_core = 1'b1;
      rx_pin = 1'b1;
   endtask

   task automatic t_ext_change();
      logic [7:0] v;
      @(negedge clk);
      cts_n = 1'b0;
      cyc(2);
      chk("R3 cts level after sync", sts_rdata[4], 1'b1);
      chk("R4 flag not yet", sts_rdata[0], 1'b0);
      cyc(1);
      chk("R4 cts fall flagged", sts_rdata, 8'h11);
      chk("R10 irq off when disabled", msi_irq, 1'b0);
      rd_sts(v);
      chk("R6 read value", v, 8'h11);
      chk("R6 cleared keeps level", sts_rdata, 8'h10);
      cyc(5);
      chk("R4 set only once", sts_rdata, 8'h10);
      @(negedge clk);
      cts_n = 1'b1;
      cyc(3);
      chk("R4 cts rise flagged", sts_rdata, 8'h01);
      rd_sts(v);
      @(negedge clk);
      dsr_n = 1'b0;
      cd_n = 1'b0;
      cyc(3);
      chk("R3 R4 dsr and cd", sts_rdata, 8'hAA);
      rd_sts(v);
      chk("R6 clear dsr cd", sts_rdata, 8'hA0);
      @(negedge clk);
      dsr_n = 1'b1;
      cd_n = 1'b1;
      cyc(3);
      chk("R4 dsr cd release", sts_rdata, 8'h0A);
      rd_sts(v);
      chk("R6 all clear", sts_rdata, 8'h00);
   endtask

   task automatic t_ri();
      logic [7:0] v;
      @(negedge clk);
      ri_n = 1'b0;
      cyc(3);
      chk("R5 ri asserted no flag", sts_rdata, 8'h40);
      @(negedge clk);
      ri_n = 1'b1;
      cyc(3);
      chk("R5 ri trailing flag", sts_rdata, 8'h04);
      rd_sts(v);
      chk("R6 ri cleared", sts_rdata, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      msi_en = 1'b1;
      @(negedge clk);
      cts_n = 1'b0;
      cyc(3);
      chk("R10 irq raised", msi_irq, 1'b1);
      msi_en = 1'b0;
      #1;
      chk("R10 irq masked", msi_irq, 1'b0);
      msi_en = 1'b1;
      #1;
      chk("R10 irq unmasked", msi_irq, 1'b1);
      rd_sts(v);
      chk("R10 irq after read", msi_irq, 1'b0);
      @(negedge clk);
      cts_n = 1'b1;
      cyc(3);
      rd_sts(v);
      msi_en = 1'b0;
      chk("R6 irq test clean", sts_rdata, 8'h00);
   endtask

   task automatic t_loop();
      logic [7:0] v;
      wr_ctl(8'h10);
      chk("R9 pins parked", pins(), 4'hF);
      chk("R8 loop idle status", sts_rdata, 8'h00);
      wr_ctl(8'h1F);
      chk("R9 pins parked all set", pins(), 4'hF);
      cyc(1);
      chk("R8 loop all high", sts_rdata, 8'hFB);
      rd_sts(v);
      chk("R6 loop clear", sts_rdata, 8'hF0);
      @(negedge clk);
      cts_n = 1'b0;
      dsr_n = 1'b0;
      cd_n = 1'b0;
      cyc(4);
      chk("R8 external ignored", sts_rdata, 8'hF0);
      @(negedge clk);
      cts_n = 1'b1;
      dsr_n = 1'b1;
      cd_n = 1'b1;
      cyc(4);
      chk("R8 external ignored release", sts_rdata, 8'hF0);
      wr_ctl(8'h12);
      cyc(1);
      chk("R8 rts to cts", sts_rdata, 8'h1E);
      rd_sts(v);
      wr_ctl(8'h11);
      cyc(1);
      chk("R8 dtr to dsr", sts_rdata, 8'h23);
      rd_sts(v);
      wr_ctl(8'h14);
      cyc(1);
      chk("R8 op1 to ri", sts_rdata, 8'h42);
      rd_sts(v);
      wr_ctl(8'h18);
      cyc(1);
      chk("R8 op2 to cd", sts_rdata, 8'h8C);
      rd_sts(v);
      chk("R6 loop cd clear", sts_rdata, 8'h80);
      @(negedge clk);
      tx_core = 1'b0;
      rx_pin = 1'b1;
      #1;
      chk("R9 tx pin held", tx_pin, 1'b1);
      chk("R9 loop rx low", rx_core, 1'b0);
      tx_core = 1'b1;
      rx_pin = 1'b0;
      #1;
      chk("R9 rx pin ignored", rx_core, 1'b1);
      rx_pin = 1'b1;
   endtask

   task automatic t_coincide();
      logic [7:0] v;
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = 8'h1A;
      @(negedge clk);
      ctl_wr = 1'b0;
      sts_rd = 1'b1;
      v = sts_rdata;
      @(negedge clk);
      sts_rd = 1'b0;
      chk("R7 value during read", v[3:0], 4'h0);
      chk("R7 flag kept", sts_rdata, 8'h91);
      rd_sts(v);
      chk("R6 flag cleared later", sts_rdata, 8'h90);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_ctrl();
      t_ext_change();
      t_ri();
      t_irq();
      t_loop();
      t_coincide();
      wr_ctl(8'h00);
      cyc(2);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule